// File: doc/BRIEF.md
# Low-Speed USB Bit-Level Packet Receiver

This block takes the two wires of a low-speed USB differential bus and turns each packet on them into a series of bytes. It runs from a 12 MHz clock, and one bit time lasts eight clocks. The line is idle in the J state, with dMinus high and dPlus low. A K state has dMinus low and dPlus high. SE0 has both wires low.

After reset, the receiver waits until the bus has stayed in J for a while. It then looks for the J-to-K edges of the sync field and locks its sampling phase to them. Once it has seen the two K bits that close the sync field, it receives data. It undoes the NRZI coding, drops the stuffed bits and packs the bits least significant first. Each finished byte goes out on a write strobe with its buffer index.

An SE0 inside a byte ends the packet. The receiver then pulses a completion strobe with the byte count, or it discards a packet that is too short. Two other events also abort the packet: a buffer overflow and a sync field that never completes. Each of these pulses its own error strobe. After any ending the receiver goes back to waiting for idle. CRC, packet ID meaning and the reply path belong to other blocks.

Top module: `lsUsbRx`

## Requirements
- R1: While rst_n is low and on the first cycles after it, byteValid, pktDone, errOverflow and errSync are 0, and byteCount is 0.
- R2: The receiver starts looking for a sync edge only after the bus has been J continuously for 8 bit times (64 clocks). While it waits for this it applies no timeout. A packet that starts sooner after a disturbance is not received.
- R3: Data reception starts only after two events in order. First, dMinus falls from J to K. Then, one and a half bit times later (12 clocks), the line samples as K. If the line samples as anything else, the receiver keeps hunting for the next falling edge.
- R4: After a failed K check, the next falling edge must arrive within 2 bit times. If it does not, errSync pulses for one cycle, no byte is written and the receiver returns to the idle wait.
- R5: At the bit centre, the same level as the previous bit gives data 1 and a change of level gives data 0. The receiver packs eight data bits, the first one into bit 0. Each byte appears on byteData with a one-cycle byteValid. byteAddr is 0 for the first byte of a packet and rises by one for each later byte.
- R6: Six consecutive data 1 bits may occur, and the last bit of the sync field counts as one of them. The bit after such a run is a stuffed bit. The receiver discards it and restarts the count of ones.
- R7: SE0 at the sample of bit position 1 to 7 of a byte ends the packet, and the partial byte is dropped. SE0 at the sample of bit position 0 reads as K and reception goes on.
- R8: When a packet ends with at least 3 bytes written, pktDone pulses for one cycle. byteCount then equals the number of bytes written.
- R9: A packet that ends with fewer than 3 bytes gives no pktDone and no error strobe.
- R10: With the buffer at 8 bytes, the first 8 bytes are written. The ninth completed byte is not written. Instead errOverflow pulses for one cycle and pktDone does not come.
- R11: Every transition on dMinus during reception moves the next sample to 4 clocks after that transition. A packet sent with 9-clock bits is therefore still received correctly.
- R12: After a completion, a short packet, an overflow or a sync error, the next well-formed packet is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dPlus | input | 1 | Bus D+ wire, asynchronous |
| dMinus | input | 1 | Bus D- wire, asynchronous |
| byteData | output | 8 | Received byte, valid with byteValid |
| byteValid | output | 1 | One-cycle write strobe for byteData |
| byteAddr | output | 3 | Buffer index of the byte being written |
| byteCount | output | 4 | Bytes written in the current or last packet |
| pktDone | output | 1 | One-cycle pulse at a valid end of packet |
| errOverflow | output | 1 | One-cycle pulse when the packet overruns the buffer |
| errSync | output | 1 | One-cycle pulse when sync detection times out |

## Verification
A sampling phase that has drifted, or a count of ones that is wrong, corrupts the byte being assembled. The bad value shows on byteData within one byte time, which is 64 clocks. A wrong bit position or byte counter instead shows as a premature or missing pktDone, or as a byteCount that does not match. This appears a few clocks after the SE0 that closes the packet.

The bench sends packets at a random clock phase and with random contents. It also sends stuffing runs, stretched 9-clock bits, SE0 glitches and dribble bits at byte starts, broken sync fields, and packets that are too short or too long. It compares every written byte and every strobe with a model of the line coding.

// File: rtl/lsRxPkg.sv
package lsRxPkg;

  typedef enum logic [2:0] {
    ST_IDLEWAIT,
    ST_HUNT,
    ST_CONFIRM,
    ST_RETRY,
    ST_RECV
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic armConfirm;  // load phase counter for the second-K check
    logic startRx;     // clear decoder state at start of data
    logic rxEn;        // decode bits on sample ticks
    logic writeByte;   // commit the byte completing this cycle
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic jLine;
    logic kLine;
    logic fallEdge;
    logic tick;
    logic byteReady;
    logic eop;
    logic bufFull;
  } dpStat_t;

endpackage

// File: rtl/lsRxSync.sv
module lsRxSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/lsRxDatapath.sv
module lsRxDatapath
  import lsRxPkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int BUF_BYTES    = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int HALF_BIT    = CLKS_PER_BIT / 2,
  localparam int PHASE_W     = $clog2(HALF_BIT + CLKS_PER_BIT),
  localparam int CNT_W       = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W      = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dPlus,
  input  logic              dMinus,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  output logic [7:0]        byteData,
  output logic              byteValid,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [CNT_W-1:0]  byteCount
);

  localparam logic [PHASE_W-1:0] CONFIRM_LOAD = PHASE_W'(HALF_BIT + CLKS_PER_BIT - 1);
  localparam logic [PHASE_W-1:0] EDGE_LOAD    = PHASE_W'(HALF_BIT - 1);
  localparam logic [PHASE_W-1:0] BIT_LOAD     = PHASE_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0]   FULL_CNT     = CNT_W'(BUF_BYTES);
  localparam logic [2:0]         STUFF_RUN    = 3'd6;

  logic [1:0] lineSync;
  logic dmS, dpS, dmPrev;

  lsRxSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dPlus, dMinus}),
    .dout (lineSync)
  );

  assign dmS = lineSync[0];
  assign dpS = lineSync[1];

  logic [PHASE_W-1:0] phaseCnt;
  logic [2:0]         onesCnt;
  logic [2:0]         bitCnt;
  logic [7:0]         shiftReg;
  logic               prevLvl;
  logic [CNT_W-1:0]   byteCnt;

  logic edgeAny, realign, tick, se0, bitVal, stuffSlot, sampleRx, eopNow;
  logic [7:0] nextByte;

  assign edgeAny   = dmS ^ dmPrev;
  assign realign   = ctl.rxEn & edgeAny;
  assign tick      = (phaseCnt == '0) & ~realign;
  assign se0       = ~dmS & ~dpS;
  assign bitVal    = (dmS == prevLvl);
  assign stuffSlot = (onesCnt == STUFF_RUN);
  assign sampleRx  = ctl.rxEn & tick;
  assign eopNow    = sampleRx & se0 & (bitCnt != 3'd0);
  assign nextByte  = {bitVal, shiftReg[7:1]};

  assign stat.jLine     = dmS & ~dpS;
  assign stat.kLine     = ~dmS & dpS;
  assign stat.fallEdge  = dmPrev & ~dmS;
  assign stat.tick      = tick;
  assign stat.eop       = eopNow;
  assign stat.byteReady = sampleRx & ~eopNow & ~stuffSlot & (bitCnt == 3'd7);
  assign stat.bufFull   = (byteCnt == FULL_CNT);

  // Bit-phase counter: re-centred on every D- transition while receiving
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      dmPrev   <= 1'b0;
    end else begin
      dmPrev <= dmS;
      if (ctl.armConfirm)          phaseCnt <= CONFIRM_LOAD;
      else if (realign)            phaseCnt <= EDGE_LOAD;
      else if (phaseCnt == '0)     phaseCnt <= BIT_LOAD;
      else                         phaseCnt <= phaseCnt - 1'b1;
    end
  end

  // NRZI decode, destuffing and byte assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesCnt  <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      prevLvl  <= 1'b0;
    end else if (ctl.startRx) begin
      onesCnt  <= 3'd1;      // final sync bit is a data 1
      bitCnt   <= '0;
      shiftReg <= '0;
      prevLvl  <= 1'b0;      // sync ends on K
    end else if (sampleRx && !eopNow) begin
      prevLvl <= dmS;
      if (stuffSlot) begin
        onesCnt <= '0;
      end else begin
        onesCnt  <= bitVal ? onesCnt + 3'd1 : 3'd0;
        shiftReg <= nextByte;
        bitCnt   <= bitCnt + 3'd1;
      end
    end
  end

  // Buffer write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteCnt   <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteAddr  <= '0;
    end else begin
      byteValid <= ctl.writeByte;
      if (ctl.startRx) begin
        byteCnt <= '0;
      end else if (ctl.writeByte) begin
        byteData <= nextByte;
        byteAddr <= byteCnt[ADDR_W-1:0];
        byteCnt  <= byteCnt + 1'b1;
      end
    end
  end

  assign byteCount = byteCnt;

endmodule

// File: rtl/lsRxControl.sv
module lsRxControl
  import lsRxPkg::*;
#(
  parameter int CLKS_PER_BIT  = 8,
  parameter int BUF_BYTES     = 8,
  parameter int MIN_BYTES     = 3,
  parameter int IDLE_BITS     = 8,
  parameter int SYNC_WIN_BITS = 2,
  localparam int CNT_W        = $clog2(BUF_BYTES + 1),
  localparam int IDLE_CLKS    = IDLE_BITS * CLKS_PER_BIT,
  localparam int WIN_CLKS     = SYNC_WIN_BITS * CLKS_PER_BIT,
  localparam int QMAX         = (IDLE_CLKS > WIN_CLKS) ? IDLE_CLKS : WIN_CLKS,
  localparam int QW           = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStat_t          stat,
  input  logic [CNT_W-1:0] byteCount,
  output dpCtl_t           ctl,
  output logic             pktDone,
  output logic             errOverflow,
  output logic             errSync
);

  localparam logic [QW-1:0]    IDLE_LAST = QW'(IDLE_CLKS - 1);
  localparam logic [QW-1:0]    WIN_LAST  = QW'(WIN_CLKS - 1);
  localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(MIN_BYTES);

  rxState_t state, nxt;
  logic [QW-1:0] quietCnt;
  logic doneHit, ovfHit, syncHit;

  always_comb begin
    ctl     = '0;
    nxt     = state;
    doneHit = 1'b0;
    ovfHit  = 1'b0;
    syncHit = 1'b0;
    case (state)
      ST_IDLEWAIT: begin
        if (stat.jLine && quietCnt == IDLE_LAST) nxt = ST_HUNT;
      end
      ST_HUNT: begin
        if (stat.fallEdge) begin
          ctl.armConfirm = 1'b1;
          nxt            = ST_CONFIRM;
        end
      end
      ST_CONFIRM: begin
        if (stat.tick) begin
          if (stat.kLine) begin
            ctl.startRx = 1'b1;
            nxt         = ST_RECV;
          end else begin
            nxt = ST_RETRY;
          end
        end
      end
      ST_RETRY: begin
        if (stat.fallEdge) begin
          ctl.armConfirm = 1'b1;
          nxt            = ST_CONFIRM;
        end else if (quietCnt == WIN_LAST) begin
          syncHit = 1'b1;
          nxt     = ST_IDLEWAIT;
        end
      end
      ST_RECV: begin
        ctl.rxEn = 1'b1;
        if (stat.eop) begin
          doneHit = (byteCount >= MIN_CNT);
          nxt     = ST_IDLEWAIT;
        end else if (stat.byteReady) begin
          if (stat.bufFull) begin
            ovfHit = 1'b1;
            nxt    = ST_IDLEWAIT;
          end else begin
            ctl.writeByte = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLEWAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLEWAIT;
      quietCnt    <= '0;
      pktDone     <= 1'b0;
      errOverflow <= 1'b0;
      errSync     <= 1'b0;
    end else begin
      state       <= nxt;
      pktDone     <= doneHit;
      errOverflow <= ovfHit;
      errSync     <= syncHit;
      if (nxt != state)               quietCnt <= '0;
      else if (state == ST_IDLEWAIT)  quietCnt <= stat.jLine ? quietCnt + 1'b1 : '0;
      else if (state == ST_RETRY)     quietCnt <= quietCnt + 1'b1;
      else                            quietCnt <= '0;
    end
  end

endmodule

// File: rtl/lsUsbRx.sv
module lsUsbRx
  import lsRxPkg::*;
#(
  parameter int CLKS_PER_BIT  = 8,
  parameter int BUF_BYTES     = 8,
  parameter int MIN_BYTES     = 3,
  parameter int IDLE_BITS     = 8,
  parameter int SYNC_WIN_BITS = 2,
  localparam int CNT_W        = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W       = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dPlus,
  input  logic              dMinus,
  output logic [7:0]        byteData,
  output logic              byteValid,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [CNT_W-1:0]  byteCount,
  output logic              pktDone,
  output logic              errOverflow,
  output logic              errSync
);

  dpCtl_t  ctl;
  dpStat_t stat;

  lsRxDatapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .BUF_BYTES   (BUF_BYTES)
  ) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dPlus    (dPlus),
    .dMinus   (dMinus),
    .ctl      (ctl),
    .stat     (stat),
    .byteData (byteData),
    .byteValid(byteValid),
    .byteAddr (byteAddr),
    .byteCount(byteCount)
  );

  lsRxControl #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .BUF_BYTES    (BUF_BYTES),
    .MIN_BYTES    (MIN_BYTES),
    .IDLE_BITS    (IDLE_BITS),
    .SYNC_WIN_BITS(SYNC_WIN_BITS)
  ) uCtl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat       (stat),
    .byteCount  (byteCount),
    .ctl        (ctl),
    .pktDone    (pktDone),
    .errOverflow(errOverflow),
    .errSync    (errSync)
  );

endmodule

// File: rtl/lsUsbRxChecker.sv
module lsUsbRxChecker #(
  parameter int BUF_BYTES = 8,
  parameter int MIN_BYTES = 3,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W   = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byteValid,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [CNT_W-1:0]  byteCount,
  input logic              pktDone,
  input logic              errOverflow,
  input logic              errSync
);

  // R5: writes are single-cycle strobes, never back to back
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |=> !byteValid);

  // R5: the running count is one past the index just written
  a_r5_addr_follows_count: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> (CNT_W'(byteAddr) + CNT_W'(1)) == byteCount);

  // R8: completion only with enough bytes, count held steady
  a_r8_done_min_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |-> byteCount >= CNT_W'(MIN_BYTES));

  a_r8_done_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |-> $stable(byteCount));

  // R10: overflow only once the buffer is full
  a_r10_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    errOverflow |-> byteCount == CNT_W'(BUF_BYTES));

  // R12: endings and writes are mutually exclusive
  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pktDone, errOverflow, errSync, byteValid}));

endmodule

bind lsUsbRx lsUsbRxChecker #(
  .BUF_BYTES(BUF_BYTES),
  .MIN_BYTES(MIN_BYTES)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byteValid  (byteValid),
  .byteAddr   (byteAddr),
  .byteCount  (byteCount),
  .pktDone    (pktDone),
  .errOverflow(errOverflow),
  .errSync    (errSync)
);

// File: tb/sim_lsUsbRx.sv
module sim_lsUsbRx;

  localparam int BUF = 8;
  localparam int BLEN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dPlus = 1'b0;
  logic dMinus = 1'b1;
  logic [7:0] byteData;
  logic       byteValid;
  logic [2:0] byteAddr;
  logic [3:0] byteCount;
  logic       pktDone, errOverflow, errSync;

  always #4 clk = ~clk;

  lsUsbRx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .dPlus      (dPlus),
    .dMinus     (dMinus),
    .byteData   (byteData),
    .byteValid  (byteValid),
    .byteAddr   (byteAddr),
    .byteCount  (byteCount),
    .pktDone    (pktDone),
    .errOverflow(errOverflow),
    .errSync    (errSync)
  );

  // Output monitor (cumulative; tests take baselines)
  logic [7:0] gotD [0:255];
  int         gotA [0:255];
  int gotN = 0, doneN = 0, lastDoneCnt = 0, ovfN = 0, syncN = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byteValid) begin
        gotD[gotN & 255] = byteData;
        gotA[gotN & 255] = int'(byteAddr);
        gotN = gotN + 1;
      end
      if (pktDone) begin
        doneN = doneN + 1;
        lastDoneCnt = int'(byteCount);
      end
      if (errOverflow) ovfN = ovfN + 1;
      if (errSync) syncN = syncN + 1;
    end
  end

  int total = 0, bad = 0;
  logic [7:0] pkt [0:15];
  int glitchHits = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lvl: 1 = J, 0 = K, 2 = SE0
  task automatic sendLvl(input int lvl, input int len);
    dMinus = (lvl == 1);
    dPlus  = (lvl == 0);
    repeat (len) @(negedge clk);
  endtask

  task automatic sendPacket(input int n, input int blen, input int idleBits,
                            input bit glitch, input bit dribble);
    int level;
    int ones;
    sendLvl(1, idleBits * blen);
    level = 1;
    for (int i = 0; i < 8; i++) begin
      if (((8'h80 >> i) & 1) == 0) level ^= 1;
      sendLvl(level, blen);
    end
    ones = 1;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        if (pkt[k][i]) ones++;
        else begin ones = 0; level ^= 1; end
        if (glitch && k > 0 && i == 0 && level == 0) begin
          glitchHits++;
          sendLvl(2, blen);
        end else begin
          sendLvl(level, blen);
        end
        if (ones == 6) begin
          level ^= 1;
          sendLvl(level, blen);
          ones = 0;
        end
      end
    end
    if (dribble) begin
      level ^= 1;
      sendLvl(level, blen);
    end
    sendLvl(2, 2 * blen);
    sendLvl(1, 12 * blen);
  endtask

  task automatic runPkt(input int n, input int blen, input bit glitch,
                        input bit dribble, input string tag);
    int g0, d0, o0, s0, expW;
    g0 = gotN; d0 = doneN; o0 = ovfN; s0 = syncN;
    sendPacket(n, blen, 12, glitch, dribble);
    expW = (n > BUF) ? BUF : n;
    chk(gotN - g0 == expW, tag, "bytes written", gotN - g0, expW);
    for (int k = 0; k < expW && k < gotN - g0; k++) begin
      chk(gotD[(g0 + k) & 255] == pkt[k], tag, "byte value",
          int'(gotD[(g0 + k) & 255]), int'(pkt[k]));
      chk(gotA[(g0 + k) & 255] == k, "R5", "byte address",
          gotA[(g0 + k) & 255], k);
    end
    if (n > BUF) begin
      chk(ovfN - o0 == 1, "R10", "overflow pulses", ovfN - o0, 1);
      chk(doneN - d0 == 0, "R10", "done after overflow", doneN - d0, 0);
    end else if (n < 3) begin
      chk(doneN - d0 == 0, "R9", "done on short packet", doneN - d0, 0);
      chk(ovfN - o0 == 0, "R9", "overflow on short packet", ovfN - o0, 0);
    end else begin
      chk(doneN - d0 == 1, "R8", "done pulses", doneN - d0, 1);
      chk(lastDoneCnt == n, "R8", "byteCount at done", lastDoneCnt, n);
      chk(ovfN - o0 == 0, "R8", "no overflow", ovfN - o0, 0);
    end
    chk(syncN - s0 == 0, "R4", "no sync error on good packet", syncN - s0, 0);
  endtask

  bit wd = 1'b0;

  initial begin
    void'($urandom(32'h5EED_0042));
    fork
      begin : tests
        int g0, d0, s0, n;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk(byteValid == 0 && pktDone == 0 && errOverflow == 0 && errSync == 0,
            "R1", "strobes in reset",
            {byteValid, pktDone, errOverflow, errSync}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byteCount == 0 && byteValid == 0, "R1", "state after reset",
            int'(byteCount), 0);

        // R5: directed short-run packet
        pkt[0] = 8'h2D; pkt[1] = 8'h00; pkt[2] = 8'h10;
        runPkt(3, BLEN, 0, 0, "R5");

        // R6: long ones runs force stuffing
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'hFF;
        pkt[4] = 8'h3F;
        runPkt(5, BLEN, 0, 0, "R6");

        // R5/R12: random packets back to back
        for (int p = 0; p < 6; p++) begin
          n = 3 + int'($urandom_range(0, BUF - 3));
          for (int k = 0; k < n; k++) pkt[k] = 8'($urandom);
          runPkt(n, BLEN, 0, 0, "R5");
        end

        // R9: too short
        pkt[0] = 8'hC3; pkt[1] = 8'h5A;
        runPkt(2, BLEN, 0, 0, "R9");

        // R10: overflow
        for (int k = 0; k < BUF + 2; k++) pkt[k] = 8'($urandom);
        runPkt(BUF + 2, BLEN, 0, 0, "R10");

        // R7: SE0 at each byte's first bit is read as K
        for (int k = 0; k < 5; k++) pkt[k] = 8'h02;
        glitchHits = 0;
        runPkt(5, BLEN, 1, 0, "R7");
        chk(glitchHits > 0, "R7", "glitches applied", glitchHits, 1);

        // R7: dribble bit before EOP
        pkt[0] = 8'h81; pkt[1] = 8'h7F; pkt[2] = 8'hA5; pkt[3] = 8'h00;
        runPkt(4, BLEN, 0, 1, "R7");

        // R11: stretched 9-clock bits with frequent transitions
        pkt[0] = 8'h00; pkt[1] = 8'h55; pkt[2] = 8'hAA; pkt[3] = 8'h00;
        runPkt(4, 9, 0, 0, "R11");

        // R3/R4: a lone K bit on idle bus
        g0 = gotN; s0 = syncN; d0 = doneN;
        sendLvl(1, 12 * BLEN);
        sendLvl(0, BLEN);
        sendLvl(1, 30 * BLEN);
        chk(gotN - g0 == 0, "R3", "bytes from lone K", gotN - g0, 0);
        chk(syncN - s0 == 1, "R4", "sync error pulses", syncN - s0, 1);

        // R2: packet too soon after disturbance is not received
        g0 = gotN; s0 = syncN; d0 = doneN;
        sendLvl(2, 2 * BLEN);
        sendLvl(1, 3 * BLEN);
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
        sendPacket(3, BLEN, 0, 0, 0);
        chk(gotN - g0 == 0, "R2", "bytes without idle", gotN - g0, 0);
        chk(doneN - d0 == 0, "R2", "done without idle", doneN - d0, 0);
        chk(syncN - s0 == 1, "R4", "sync timeout on SE0 burst", syncN - s0, 1);

        // R12: normal reception afterwards
        pkt[0] = 8'h69; pkt[1] = 8'hE1; pkt[2] = 8'h0F; pkt[3] = 8'hF0;
        runPkt(4, BLEN, 0, 0, "R12");
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule